// File: doc/BRIEF.md
# Transport Stream Packet Identifier Bitmap Filter

This block sits on two byte-serial MPEG transport streams and lets only selected packets through. Every stream has its own filter, a 1024-byte bitmap with one bit for each of the 8192 possible packet identifiers (PIDs). A bit at 1 means "discard this PID" and a bit at 0 means "forward it". Identifiers 0x00 to 0x1F are always forwarded, whatever their bits hold. The block pulls the 13-bit PID out of header bytes 1 and 2 of each packet and reads the matching bitmap byte. The whole packet then goes out, or none of it does. The stream is delayed by a fixed four cycles, so the verdict is ready before the first byte reaches the output.

Software reaches the bitmaps indirectly through a small register window. An index-low register and an index-high register hold a byte pointer. The high register also carries the filter select. A data register then reads or writes the whole byte at that pointer, so single bits can be changed by read-modify-write. At start-up, software sets every byte to 0xFF, which blocks everything except the fixed low identifiers, and then opens PIDs one at a time.

Each bitmap is a single-port RAM that is shared between packet lookups and host accesses. The per-stream header tracker is a state machine with these states:
- LN_WAIT: no packet in progress.
- LN_HDR1: enters on a start-of-packet byte, from any state.
- LN_HDR2: follows the next byte.
- LN_BODY: follows the next byte, and that byte launches the lookup.

The host port state machine has these states:
- HP_IDLE: no access pending.
- HP_FETCH: enters when an index register is written, and leaves for HP_LOAD once the RAM grants the access.
- HP_LOAD: captures the fetched byte, then returns to HP_IDLE.
- HP_STORE: enters when the data register is written, and returns to HP_IDLE once the RAM grants the access.

Top module: `pidf_filter_top`

## Requirements
- R1: After reset, out_valid and out_sop are all 0, host_busy is 0 and host_rdata is 0x00.
- R2: The PID is {byte1[4:0], byte2}. Bits 7:5 of byte 1 are ignored. The verdict comes from bit PID[2:0] of byte PID[12:3] in the stream's bitmap. A 1 drops every byte of the packet and a 0 forwards every byte.
- R3: A forwarded byte leaves exactly 4 cycles after it entered, with its data and start-of-packet flag unchanged. A dropped packet never raises out_valid.
- R4: PIDs below 0x20 (bitmap bytes 0 to 3) are always forwarded, whatever those bits hold.
- R5: A packet whose first byte is not 0x47 is dropped.
- R6: Stream 0 is judged only by filter 0 and stream 1 only by filter 1.
- R7: The host register selects are host_sel 0 for index bits 7:0, host_sel 1 for index bits 9:8 in data bits 1:0 with the filter select in data bit 2, and host_sel 2 for the data register. Reading select 0 or 1 returns the stored pointer in that layout, and select 3 reads 0x00. host_rdata is valid in the cycle after host_rd.
- R8: Writing either index register starts a fetch, and host_busy rises the next cycle. Once host_busy is 0, the data register reads the pointed byte. Writing the data register stores that byte in the RAM, and a later fetch returns it.
- R9: When a host RAM access and a packet lookup meet on the same bitmap, the lookup wins and the host access completes one cycle later. host_busy never stays high for more than 3 cycles in a row.
- R10: A register write made while host_busy is 1 is ignored.
- R11: Back-to-back packets each get their own verdict, and the verdict switches exactly at the next packet's start byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 2 | Byte valid per stream; held high for all 188 bytes of a packet |
| in_sop | input | 2 | Start-of-packet flag per stream |
| in_data | input | 16 | Stream bytes, stream k at bits 8k+7:8k |
| out_valid | output | 2 | Forwarded byte valid per stream |
| out_sop | output | 2 | Forwarded start-of-packet flag |
| out_data | output | 16 | Forwarded bytes, zero when not valid |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_sel | input | 2 | Register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| host_busy | output | 1 | Indirect access in progress |

## Verification
A byte driven in cycle n is due at the output in cycle n+4. The bench therefore writes its expected output into a ring slot four cycles ahead of the cycle in which it drives the byte, and compares every stream output at each falling edge against the slot for that cycle. Register read data is sampled one cycle after the read strobe. host_busy is sampled cycle by cycle after a write timed to land on a lookup: an index write that collides with a lookup must show three busy cycles and then idle, and a colliding data write must show two.

// File: rtl/pidf_pkg.sv
package pidf_pkg;

    localparam int PID_W            = 13;
    localparam int BITSEL_W         = 3;
    localparam int BYTE_W           = 8;
    localparam int IDX_W            = PID_W - BITSEL_W;
    localparam int MAP_BYTES        = 1 << IDX_W;
    localparam int PID_HI_W         = PID_W - BYTE_W;
    localparam int IDX_HI_W         = IDX_W - BYTE_W;
    localparam int N_FILT           = 2;
    localparam int FSEL_W           = (N_FILT > 1) ? $clog2(N_FILT) : 1;
    localparam int FIXED_PASS_BYTES = 4;
    localparam int HDR_BYTES        = 3;
    localparam int LOOKUP_LAT       = 1;
    localparam int PIPE_LAT         = HDR_BYTES + LOOKUP_LAT;
    localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'h47;

    localparam logic [1:0] REG_IDX_LO = 2'd0;
    localparam logic [1:0] REG_IDX_HI = 2'd1;
    localparam logic [1:0] REG_DATA   = 2'd2;

    typedef enum logic [1:0] {
        LN_WAIT,
        LN_HDR1,
        LN_HDR2,
        LN_BODY
    } lane_state_e;

    typedef enum logic [1:0] {
        HP_IDLE,
        HP_FETCH,
        HP_LOAD,
        HP_STORE
    } host_state_e;

    typedef struct packed {
        logic              valid;
        logic              sop;
        logic [BYTE_W-1:0] data;
    } beat_t;

endpackage

// File: rtl/pidf_bitmap_ram.sv
module pidf_bitmap_ram #(
    parameter int DEPTH = 1024,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/pidf_lane.sv
module pidf_lane
    import pidf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic [BYTE_W-1:0] out_data,
    input  logic              hp_req,
    input  logic              hp_we,
    input  logic [IDX_W-1:0]  hp_idx,
    input  logic [BYTE_W-1:0] hp_wdata,
    output logic              hp_grant,
    output logic [BYTE_W-1:0] hp_rdata
);

    lane_state_e st_q, st_d;

    logic                sync_ok_q;
    logic [PID_HI_W-1:0] pid_hi_q;
    logic [BITSEL_W-1:0] bitsel_q;
    logic                fixed_q;
    logic                lk_pend_q;
    logic                pass_q;

    logic                lk_fire;
    logic [PID_W-1:0]    pid_now;
    logic [IDX_W-1:0]    lk_idx;

    logic                ram_en;
    logic                ram_we;
    logic [IDX_W-1:0]    ram_addr;
    logic [BYTE_W-1:0]   ram_rdata;

    beat_t dly_q [PIPE_LAT];

    // header tracker: next state
    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            if (in_sop) begin
                st_d = LN_HDR1;
            end else begin
                unique case (st_q)
                    LN_WAIT: st_d = LN_WAIT;
                    LN_HDR1: st_d = LN_HDR2;
                    LN_HDR2: st_d = LN_BODY;
                    LN_BODY: st_d = LN_BODY;
                    default: st_d = LN_WAIT;
                endcase
            end
        end
    end

    // header tracker: state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LN_WAIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign pid_now = {pid_hi_q, in_data};
    assign lk_idx  = pid_now[PID_W-1:BITSEL_W];
    assign lk_fire = in_valid && !in_sop && (st_q == LN_HDR2);

    // header capture and verdict
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_ok_q <= 1'b0;
            pid_hi_q  <= '0;
            bitsel_q  <= '0;
            fixed_q   <= 1'b0;
            lk_pend_q <= 1'b0;
            pass_q    <= 1'b0;
        end else begin
            lk_pend_q <= lk_fire;
            if (in_valid && in_sop) begin
                sync_ok_q <= (in_data == SYNC_BYTE);
            end
            if (in_valid && !in_sop && (st_q == LN_HDR1)) begin
                pid_hi_q <= in_data[PID_HI_W-1:0];
            end
            if (lk_fire) begin
                bitsel_q <= pid_now[BITSEL_W-1:0];
                fixed_q  <= (lk_idx < IDX_W'(FIXED_PASS_BYTES));
            end
            if (lk_pend_q) begin
                pass_q <= sync_ok_q && (fixed_q || !ram_rdata[bitsel_q]);
            end
        end
    end

    // fixed-latency byte delay line
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PIPE_LAT; i++) begin
                dly_q[i] <= '0;
            end
        end else begin
            dly_q[0] <= '{valid: in_valid, sop: in_sop, data: in_data};
            for (int i = 1; i < PIPE_LAT; i++) begin
                dly_q[i] <= dly_q[i-1];
            end
        end
    end

    // outputs
    always_comb begin
        out_valid = dly_q[PIPE_LAT-1].valid && pass_q;
        out_sop   = dly_q[PIPE_LAT-1].sop && out_valid;
        out_data  = out_valid ? dly_q[PIPE_LAT-1].data : '0;
    end

    // single RAM port shared, lookup first
    assign hp_grant = hp_req && !lk_fire;
    assign ram_en   = lk_fire || hp_req;
    assign ram_we   = hp_grant && hp_we;
    assign ram_addr = lk_fire ? lk_idx : hp_idx;
    assign hp_rdata = ram_rdata;

    pidf_bitmap_ram #(
        .DEPTH (MAP_BYTES),
        .DW    (BYTE_W)
    ) u_map (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (hp_wdata),
        .rdata (ram_rdata)
    );

endmodule

// File: rtl/pidf_host_port.sv
module pidf_host_port
    import pidf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              host_busy,
    output logic              acc_req,
    output logic              acc_we,
    output logic [FSEL_W-1:0] acc_filt,
    output logic [IDX_W-1:0]  acc_idx,
    output logic [BYTE_W-1:0] acc_wdata,
    input  logic              acc_grant,
    input  logic [BYTE_W-1:0] acc_rdata
);

    host_state_e st_q, st_d;

    logic [IDX_W-1:0]  idx_q;
    logic [FSEL_W-1:0] filt_q;
    logic [BYTE_W-1:0] hold_q;
    logic [BYTE_W-1:0] rdata_q;
    logic              wr_ok;
    logic [BYTE_W-1:0] rd_mux;

    assign wr_ok = host_wr && (st_q == HP_IDLE);

    // access sequencer: next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HP_IDLE: begin
                if (wr_ok) begin
                    if (host_sel == REG_DATA) begin
                        st_d = HP_STORE;
                    end else if ((host_sel == REG_IDX_LO) || (host_sel == REG_IDX_HI)) begin
                        st_d = HP_FETCH;
                    end
                end
            end
            HP_FETCH: if (acc_grant) st_d = HP_LOAD;
            HP_LOAD:  st_d = HP_IDLE;
            HP_STORE: if (acc_grant) st_d = HP_IDLE;
            default:  st_d = HP_IDLE;
        endcase
    end

    // access sequencer: state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= HP_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        rd_mux = '0;
        unique case (host_sel)
            REG_IDX_LO: rd_mux = idx_q[BYTE_W-1:0];
            REG_IDX_HI: begin
                rd_mux[IDX_HI_W-1:0]          = idx_q[IDX_W-1:BYTE_W];
                rd_mux[IDX_HI_W +: FSEL_W]    = filt_q;
            end
            REG_DATA:   rd_mux = hold_q;
            default:    rd_mux = '0;
        endcase
    end

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            filt_q  <= '0;
            hold_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_ok) begin
                unique case (host_sel)
                    REG_IDX_LO: idx_q[BYTE_W-1:0] <= host_wdata;
                    REG_IDX_HI: begin
                        idx_q[IDX_W-1:BYTE_W] <= host_wdata[IDX_HI_W-1:0];
                        filt_q                <= host_wdata[IDX_HI_W +: FSEL_W];
                    end
                    REG_DATA:   hold_q <= host_wdata;
                    default:    ;
                endcase
            end
            if (st_q == HP_LOAD) begin
                hold_q <= acc_rdata;
            end
            if (host_rd) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign host_rdata = rdata_q;
    assign host_busy  = (st_q != HP_IDLE);
    assign acc_req    = (st_q == HP_FETCH) || (st_q == HP_STORE);
    assign acc_we     = (st_q == HP_STORE);
    assign acc_filt   = filt_q;
    assign acc_idx    = idx_q;
    assign acc_wdata  = hold_q;

endmodule

// File: rtl/pidf_filter_top.sv
module pidf_filter_top
    import pidf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_FILT-1:0]        in_valid,
    input  logic [N_FILT-1:0]        in_sop,
    input  logic [N_FILT*BYTE_W-1:0] in_data,
    output logic [N_FILT-1:0]        out_valid,
    output logic [N_FILT-1:0]        out_sop,
    output logic [N_FILT*BYTE_W-1:0] out_data,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [1:0]               host_sel,
    input  logic [BYTE_W-1:0]        host_wdata,
    output logic [BYTE_W-1:0]        host_rdata,
    output logic                     host_busy
);

    logic              acc_req;
    logic              acc_we;
    logic [FSEL_W-1:0] acc_filt;
    logic [IDX_W-1:0]  acc_idx;
    logic [BYTE_W-1:0] acc_wdata;
    logic              acc_grant;
    logic [BYTE_W-1:0] acc_rdata;

    logic [N_FILT-1:0] lane_grant;
    logic [BYTE_W-1:0] lane_rdata [N_FILT];

    pidf_host_port u_host (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_busy  (host_busy),
        .acc_req    (acc_req),
        .acc_we     (acc_we),
        .acc_filt   (acc_filt),
        .acc_idx    (acc_idx),
        .acc_wdata  (acc_wdata),
        .acc_grant  (acc_grant),
        .acc_rdata  (acc_rdata)
    );

    for (genvar k = 0; k < N_FILT; k++) begin : g_lane
        logic sel_here;
        assign sel_here = acc_req && (acc_filt == FSEL_W'(k));

        pidf_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid[k]),
            .in_sop    (in_sop[k]),
            .in_data   (in_data[BYTE_W*k +: BYTE_W]),
            .out_valid (out_valid[k]),
            .out_sop   (out_sop[k]),
            .out_data  (out_data[BYTE_W*k +: BYTE_W]),
            .hp_req    (sel_here),
            .hp_we     (acc_we),
            .hp_idx    (acc_idx),
            .hp_wdata  (acc_wdata),
            .hp_grant  (lane_grant[k]),
            .hp_rdata  (lane_rdata[k])
        );
    end

    assign acc_grant = lane_grant[acc_filt];
    assign acc_rdata = lane_rdata[acc_filt];

endmodule

// File: rtl/pidf_filter_chk.sv
module pidf_filter_chk
    import pidf_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic [N_FILT-1:0]        in_valid,
    input logic [N_FILT-1:0]        in_sop,
    input logic [N_FILT*BYTE_W-1:0] in_data,
    input logic [N_FILT-1:0]        out_valid,
    input logic [N_FILT-1:0]        out_sop,
    input logic [N_FILT*BYTE_W-1:0] out_data,
    input logic                     host_wr,
    input logic [1:0]               host_sel,
    input logic                     host_busy
);

    for (genvar k = 0; k < N_FILT; k++) begin : g_lane_chk
        // R3
        out_from_input_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid[k] |-> ($past(in_valid[k], PIPE_LAT) &&
                              out_data[BYTE_W*k +: BYTE_W] == $past(in_data[BYTE_W*k +: BYTE_W], PIPE_LAT)));

        // R3
        sop_align_chk: assert property (@(posedge clk) disable iff (rst)
            out_sop[k] |-> (out_valid[k] && $past(in_sop[k], PIPE_LAT)));

        // R5
        sync_first_chk: assert property (@(posedge clk) disable iff (rst)
            out_sop[k] |-> (out_data[BYTE_W*k +: BYTE_W] == SYNC_BYTE));
    end

    // R8
    busy_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_busy && host_sel != 2'd3) |=> host_busy);

    // R9
    busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (host_busy && $past(host_busy) && $past(host_busy, 2)) |=> !host_busy);

endmodule

bind pidf_filter_top pidf_filter_chk u_chk (.*);

// File: tb/pidf_filter_top_tb.sv
`timescale 1ns/1ps
module pidf_filter_top_tb;

    localparam int LAT   = 4;
    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  in_valid = '0;
    logic [1:0]  in_sop = '0;
    logic [15:0] in_data = '0;
    logic [1:0]  out_valid;
    logic [1:0]  out_sop;
    logic [15:0] out_data;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [1:0]  host_sel = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_busy;

    int n_cmp  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit chk_on = 1'b0;
    bit done   = 1'b0;
    string phase = "R1";

    bit         drop_m [2][8192];
    logic [9:0] ring   [2][16];

    always #2 clk = ~clk;

    pidf_filter_top u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_sop    (out_sop),
        .out_data   (out_data),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_busy  (host_busy)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // per-cycle comparison against the reference ring (R3 timing)
    always @(negedge clk) begin
        if (chk_on) begin
            for (int k = 0; k < 2; k++) begin
                logic [9:0] exp_b;
                logic [9:0] act_b;
                exp_b = ring[k][cyc % 16];
                ring[k][cyc % 16] = '0;
                act_b = {out_valid[k], out_sop[k], out_data[8*k +: 8]};
                n_cmp++;
                if (act_b !== exp_b) begin
                    n_fail++;
                    $display("FAIL R3 (%s) stream %0d cycle %0d: actual %h expected %h",
                             phase, k, cyc, act_b, exp_b);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > LIMIT && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    function automatic bit model_pass(input int k, input logic [7:0] sy, input int pid);
        return (sy == 8'h47) && ((pid < 32) || !drop_m[k][pid]);
    endfunction

    function automatic logic [7:0] model_byte(input int f, input int idx);
        logic [7:0] v;
        for (int b = 0; b < 8; b++) v[b] = drop_m[f][idx*8 + b];
        return v;
    endfunction

    task automatic hwr(input logic [1:0] s, input logic [7:0] v);
        @(posedge clk); #1;
        while (host_busy) begin @(posedge clk); #1; end
        host_wr = 1'b1; host_sel = s; host_wdata = v;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [1:0] s, output logic [7:0] v);
        @(posedge clk); #1;
        while (host_busy) begin @(posedge clk); #1; end
        host_rd = 1'b1; host_sel = s;
        @(posedge clk); #1;
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic set_ptr(input int f, input int idx);
        hwr(2'd1, 8'((f << 2) | (idx >> 8)));
        hwr(2'd0, 8'(idx & 255));
    endtask

    task automatic wr_byte(input int f, input int idx, input logic [7:0] v);
        set_ptr(f, idx);
        hwr(2'd2, v);
        for (int b = 0; b < 8; b++) drop_m[f][idx*8 + b] = v[b];
    endtask

    task automatic rd_byte(input int f, input int idx, output logic [7:0] v);
        set_ptr(f, idx);
        hrd(2'd2, v);
    endtask

    // drive one 188-byte packet on each enabled stream in parallel
    task automatic send_pkts(input logic [7:0] sy0, input int pid0, input bit en0,
                             input logic [7:0] sy1, input int pid1, input bit en1);
        bit p0, p1;
        p0 = model_pass(0, sy0, pid0);
        p1 = model_pass(1, sy1, pid1);
        for (int b = 0; b < 188; b++) begin
            @(posedge clk); #1;
            for (int k = 0; k < 2; k++) begin
                bit         en_k, p_k;
                logic [7:0] sy_k, d;
                int         pid_k;
                en_k  = (k == 0) ? en0 : en1;
                p_k   = (k == 0) ? p0 : p1;
                sy_k  = (k == 0) ? sy0 : sy1;
                pid_k = (k == 0) ? pid0 : pid1;
                if (b == 0)      d = sy_k;
                else if (b == 1) d = {3'b010, 5'(pid_k >> 8)};
                else if (b == 2) d = 8'(pid_k & 255);
                else             d = 8'(b * 7 + pid_k);
                in_valid[k] = en_k;
                in_sop[k]   = en_k && (b == 0);
                in_data[8*k +: 8] = en_k ? d : 8'h00;
                if (en_k && p_k) ring[k][(cyc + LAT) % 16] = {1'b1, (b == 0), d};
            end
        end
    endtask

    task automatic idle_streams(input int n);
        @(posedge clk); #1;
        in_valid = '0; in_sop = '0; in_data = '0;
        repeat (n) @(posedge clk);
    endtask

    initial begin
        logic [7:0] v;
        bit b2, b3, b4, b5;
        for (int k = 0; k < 2; k++) for (int i = 0; i < 16; i++) ring[k][i] = '0;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 out_valid", {6'b0, out_valid}, 8'h00);
        chk("R1 out_sop", {6'b0, out_sop}, 8'h00);
        chk("R1 host_busy", {7'b0, host_busy}, 8'h00);
        chk("R1 host_rdata", host_rdata, 8'h00);
        chk_on = 1'b1;

        // fill both bitmaps with 0xFF
        phase = "init";
        for (int f = 0; f < 2; f++) begin
            for (int idx = 0; idx < 1024; idx++) begin
                if ((idx & 255) == 0) hwr(2'd1, 8'((f << 2) | (idx >> 8)));
                hwr(2'd0, 8'(idx & 255));
                hwr(2'd2, 8'hFF);
                for (int b = 0; b < 8; b++) drop_m[f][idx*8 + b] = 1'b1;
            end
        end

        // R7 pointer readback
        set_ptr(1, 10'h3A5);
        hrd(2'd1, v); chk("R7 index-high readback", v, 8'h07);
        hrd(2'd0, v); chk("R7 index-low readback", v, 8'hA5);
        hrd(2'd3, v); chk("R7 unused select", v, 8'h00);

        // R10 write while busy is ignored
        @(posedge clk); #1;
        while (host_busy) begin @(posedge clk); #1; end
        host_wr = 1'b1; host_sel = 2'd0; host_wdata = 8'h11;
        @(posedge clk); #1;
        host_wdata = 8'h22;
        @(posedge clk); #1;
        host_wr = 1'b0;
        hrd(2'd0, v); chk("R10 write during busy ignored", v, 8'h11);

        // R2 R4 R6: blocked PID vs fixed low PID
        phase = "R2/R4";
        send_pkts(8'h47, 'h100, 1, 8'h47, 'h005, 1);
        phase = "R4 boundary";
        send_pkts(8'h47, 'h01F, 1, 8'h47, 'h020, 1);
        idle_streams(6);

        // R8 read-modify-write on filter 0
        rd_byte(0, 'h24, v); chk("R8 initial byte", v, 8'hFF);
        wr_byte(0, 'h24, v & ~8'h08);
        rd_byte(0, 'h24, v); chk("R8 byte after write", v, 8'hF7);

        phase = "R6";
        send_pkts(8'h47, 'h123, 1, 8'h47, 'h123, 1);
        phase = "R2 neighbour bit";
        send_pkts(8'h47, 'h122, 1, 8'h47, 'h000, 0);
        idle_streams(6);

        // last bitmap byte, bit 7, filter 1
        wr_byte(1, 'h3FF, 8'h7F);
        rd_byte(1, 'h3FF, v); chk("R8 last byte filter 1", v, 8'h7F);
        phase = "R2 top PID";
        send_pkts(8'h47, 'h1FFF, 1, 8'h47, 'h1FFF, 1);

        // R11 back-to-back verdict changes
        phase = "R11";
        send_pkts(8'h47, 'h123, 1, 8'h47, 'h1FFF, 1);
        send_pkts(8'h47, 'h100, 1, 8'h47, 'h020, 1);
        send_pkts(8'h47, 'h123, 1, 8'h47, 'h1FFF, 1);

        // R5 bad sync byte
        phase = "R5";
        send_pkts(8'h48, 'h123, 1, 8'h00, 'h003, 1);
        send_pkts(8'h47, 'h123, 1, 8'h47, 'h003, 1);
        idle_streams(6);

        // R9 index write colliding with a lookup on filter 0
        wr_byte(0, 'h50, 8'h3C);
        set_ptr(0, 'h000);
        phase = "R9";
        fork
            send_pkts(8'h47, 'h100, 1, 8'h47, 'h000, 0);
            begin
                repeat (2) @(posedge clk);
                #1 host_wr = 1'b1; host_sel = 2'd0; host_wdata = 8'h50;
                @(posedge clk); #1 host_wr = 1'b0;
                @(negedge clk); b2 = host_busy;
                @(negedge clk); b3 = host_busy;
                @(negedge clk); b4 = host_busy;
                @(negedge clk); b5 = host_busy;
                chk("R9 fetch busy pattern", {4'b0, b2, b3, b4, b5}, 8'h0E);
            end
        join
        hrd(2'd2, v); chk("R9 fetched own byte", v, 8'h3C);

        // R9 data write colliding with a lookup
        fork
            send_pkts(8'h47, 'h123, 1, 8'h47, 'h000, 0);
            begin
                repeat (2) @(posedge clk);
                #1 host_wr = 1'b1; host_sel = 2'd2; host_wdata = 8'h5A;
                @(posedge clk); #1 host_wr = 1'b0;
                @(negedge clk); b2 = host_busy;
                @(negedge clk); b3 = host_busy;
                @(negedge clk); b4 = host_busy;
                chk("R9 store busy pattern", {5'b0, b2, b3, b4}, 8'h06);
            end
        join
        for (int b = 0; b < 8; b++) drop_m[0]['h50*8 + b] = v[b];
        for (int b = 0; b < 8; b++) drop_m[0]['h50*8 + b] = 1'b0;
        begin
            logic [7:0] w;
            w = 8'h5A;
            for (int b = 0; b < 8; b++) drop_m[0]['h50*8 + b] = w[b];
        end
        idle_streams(6);
        rd_byte(0, 'h50, v); chk("R9 stored byte readback", v, 8'h5A);
        rd_byte(0, 'h20, v); chk("R9 lookup byte untouched", v, model_byte(0, 'h20));
        phase = "R9 after";
        send_pkts(8'h47, 'h281, 1, 8'h47, 'h000, 0);
        send_pkts(8'h47, 'h283, 1, 8'h47, 'h000, 0);
        idle_streams(8);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule